// File: doc/BRIEF.md
# Histogram Test Phase Sequencer

This block is the controller and code selector of a built-in self-test for an n-bit analog-to-digital converter. The converter is driven by a repeating triangle wave. The block holds a reference code and compares it with every converter sample. It raises a match flag while an acquisition window is open. The flag drives an external up/down accumulator through two strobes.

The block handles one code per acquisition window, so only one measured histogram word is ever needed. It runs four phases in a fixed order:
- Offset: the bottom code 0, then the top code 2^n-1.
- Gain: the codes GAIN_LO to GAIN_HI, one after another.
- DNL: every code from 0 to 2^n-1.
- INL: every code from 0 to 2^n-1.

A `start` pulse opens each window and a `win_end` pulse closes it. After the last INL window, `done` pulses once and the block goes back to idle.

The controller has four states:
- IDLE goes to ACQ on start and loads phase offset with code 0.
- ARM goes to ACQ on start.
- ACQ goes to ARM on win_end when more steps remain, and to DONE on win_end after the final INL code.
- DONE goes to IDLE unconditionally.

Top module: `hist_phase_seq`

## Requirements
- R1: After reset the block is idle. `phase` is 0, `ref_code` is 0, and `hit`, `acc_up`, `acc_dn`, `det_clr` and `done` are all 0.
- R2: `hit` is 1 in the same cycle exactly when a window is open (ACQ) and `adc_code` equals `ref_code`. Outside a window it is 0 whatever `adc_code` is.
- R3: A `start` sampled in IDLE or ARM raises `det_clr` in that same cycle and opens a window from the next cycle on. A start from IDLE also loads `phase`=0 and `ref_code`=0.
- R4: The `phase` encoding is offset=0, gain=1, DNL=2, INL=3, and the phases run in that order. The offset phase uses code 0 and then code 2^n-1.
- R5: The gain phase uses the codes GAIN_LO, GAIN_LO+1, up to GAIN_HI. GAIN_HI-GAIN_LO+1 must be a power of two.
- R6: The DNL phase and then the INL phase each use the codes 0, 1, up to 2^n-1.
- R7: `acc_dn` equals `hit` during the offset step with code 0. At every other step `acc_up` equals `hit`. The two strobes are never high together.
- R8: `win_end` has no effect outside a window, and `start` has no effect inside a window.
- R9: When `win_end` closes the final INL window (code 2^n-1), `done` is 1 for exactly the next cycle. The block is then idle, and a new start restarts at offset with code 0.
- R10: `phase` and `ref_code` change only on the clock edge after a cycle in which `win_end` or `start` was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens an acquisition window |
| win_end | input | 1 | Closes the open acquisition window |
| adc_code | input | CODE_W | Converter output sample |
| hit | output | 1 | Sample equals reference code inside a window |
| phase | output | 2 | Current test phase (0 offset, 1 gain, 2 DNL, 3 INL) |
| ref_code | output | CODE_W | Current reference code |
| acc_up | output | 1 | Accumulator count-up strobe |
| acc_dn | output | 1 | Accumulator count-down strobe |
| det_clr | output | 1 | Detector clear at the start of a step |
| done | output | 1 | One-cycle completion pulse |

## Verification
Results fall due at two different times.
- `hit`, `acc_up`, `acc_dn` and `det_clr` are combinational. They are due in the same cycle as the `adc_code` or `start` that causes them. The bench drives inputs just after the falling edge and samples them one nanosecond later.
- `phase`, `ref_code`, the opening of a window and `done` come from registers. They are due one rising edge after the `start` or `win_end` that caused them, so the bench checks them at the following falling edge.

The whole 42-window sequence is walked against a code list that the bench builds from the requirements.

// File: rtl/hist_phase_pkg.sv
package hist_phase_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_ACQ  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_OFFSET = 2'd0,
        PH_GAIN   = 2'd1,
        PH_DNL    = 2'd2,
        PH_INL    = 2'd3
    } test_phase_t;

endpackage

// File: rtl/hp_match_slice.sv
module hp_match_slice (
    input  logic sample_bit,
    input  logic ref_bit,
    input  logic eq_in,
    output logic eq_out
);
    assign eq_out = eq_in & ~(sample_bit ^ ref_bit);
endmodule

// File: rtl/hp_match_chain.sv
module hp_match_chain #(
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] sample,
    input  logic [CODE_W-1:0] ref_val,
    output logic              equal
);
    logic [CODE_W:0] eq_link;

    assign eq_link[0] = 1'b1;

    for (genvar b = 0; b < CODE_W; b++) begin : g_slice
        hp_match_slice u_slice (
            .sample_bit (sample[b]),
            .ref_bit    (ref_val[b]),
            .eq_in      (eq_link[b]),
            .eq_out     (eq_link[b+1])
        );
    end

    assign equal = eq_link[CODE_W];
endmodule

// File: rtl/hp_step_sel.sv
module hp_step_sel
    import hist_phase_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int GAIN_LO = 4,
    parameter int GAIN_HI = 11
) (
    input  test_phase_t       cur_phase,
    input  logic [CODE_W-1:0] cur_code,
    output test_phase_t       nxt_phase,
    output logic [CODE_W-1:0] nxt_code,
    output logic              last_step
);
    localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] LO_CODE  = CODE_W'(GAIN_LO);
    localparam logic [CODE_W-1:0] HI_CODE  = CODE_W'(GAIN_HI);
    localparam int                SPAN     = GAIN_HI - GAIN_LO + 1;

    if (SPAN < 1 || (SPAN & (SPAN - 1)) != 0 || GAIN_HI >= (1 << CODE_W)) begin : g_bad_span
        $error("gain code span must be a power of two inside the code range");
    end

    always_comb begin
        nxt_phase = cur_phase;
        nxt_code  = cur_code + 1'b1;
        last_step = 1'b0;
        unique case (cur_phase)
            PH_OFFSET: begin
                if (cur_code == '0) begin
                    nxt_code = TOP_CODE;
                end else begin
                    nxt_phase = PH_GAIN;
                    nxt_code  = LO_CODE;
                end
            end
            PH_GAIN: begin
                if (cur_code == HI_CODE) begin
                    nxt_phase = PH_DNL;
                    nxt_code  = '0;
                end
            end
            PH_DNL: begin
                if (cur_code == TOP_CODE) begin
                    nxt_phase = PH_INL;
                    nxt_code  = '0;
                end
            end
            PH_INL: begin
                if (cur_code == TOP_CODE) begin
                    last_step = 1'b1;
                    nxt_code  = cur_code;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hist_phase_seq.sv
module hist_phase_seq
    import hist_phase_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int GAIN_LO = 4,
    parameter int GAIN_HI = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              win_end,
    input  logic [CODE_W-1:0] adc_code,
    output logic              hit,
    output logic [1:0]        phase,
    output logic [CODE_W-1:0] ref_code,
    output logic              acc_up,
    output logic              acc_dn,
    output logic              det_clr,
    output logic              done
);
    seq_state_t        state_q, state_d;
    test_phase_t       phase_q, phase_nx;
    logic [CODE_W-1:0] code_q, code_nx;
    logic              last_step;
    logic              code_eq;
    logic              win_open;

    hp_match_chain #(.CODE_W(CODE_W)) u_match (
        .sample  (adc_code),
        .ref_val (code_q),
        .equal   (code_eq)
    );

    hp_step_sel #(
        .CODE_W  (CODE_W),
        .GAIN_LO (GAIN_LO),
        .GAIN_HI (GAIN_HI)
    ) u_step (
        .cur_phase (phase_q),
        .cur_code  (code_q),
        .nxt_phase (phase_nx),
        .nxt_code  (code_nx),
        .last_step (last_step)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)   state_d = ST_ACQ;
            ST_ARM:  if (start)   state_d = ST_ACQ;
            ST_ACQ:  if (win_end) state_d = last_step ? ST_DONE : ST_ARM;
            ST_DONE:              state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_OFFSET;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                phase_q <= PH_OFFSET;
                code_q  <= '0;
            end else if (state_q == ST_ACQ && win_end && !last_step) begin
                phase_q <= phase_nx;
                code_q  <= code_nx;
            end
        end
    end

    always_comb begin
        win_open = (state_q == ST_ACQ);
        hit      = win_open & code_eq;
        det_clr  = start & ((state_q == ST_IDLE) | (state_q == ST_ARM));
        done     = (state_q == ST_DONE);
        if (phase_q == PH_OFFSET && code_q == '0) begin
            acc_dn = hit;
            acc_up = 1'b0;
        end else begin
            acc_dn = 1'b0;
            acc_up = hit;
        end
    end

    assign phase    = phase_q;
    assign ref_code = code_q;

endmodule

// File: rtl/hist_phase_seq_chk.sv
module hist_phase_seq_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              win_end,
    input logic [CODE_W-1:0] adc_code,
    input logic              hit,
    input logic [1:0]        phase,
    input logic [CODE_W-1:0] ref_code,
    input logic              acc_up,
    input logic              acc_dn,
    input logic              det_clr,
    input logic              done
);
    localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_up && acc_dn));

    p_strobe_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_up || acc_dn) |-> hit);

    p_hit_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (adc_code == ref_code));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == 2'd3 && ref_code == TOP_CODE));

    p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_end && !start) |=> ($stable(ref_code) && $stable(phase)));

    p_clr_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        det_clr |-> start);

    p_no_clr_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(det_clr && hit));
endmodule

bind hist_phase_seq hist_phase_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .win_end  (win_end),
    .adc_code (adc_code),
    .hit      (hit),
    .phase    (phase),
    .ref_code (ref_code),
    .acc_up   (acc_up),
    .acc_dn   (acc_dn),
    .det_clr  (det_clr),
    .done     (done)
);

// File: tb/hist_phase_seq_test.sv
module hist_phase_seq_test;
    localparam int CW    = 4;
    localparam int G_LO  = 4;
    localparam int G_HI  = 11;
    localparam int TOP   = (1 << CW) - 1;
    localparam int NWIN  = 2 + (G_HI - G_LO + 1) + 2 * (TOP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          win_end = 1'b0;
    logic [CW-1:0] adc_code = '0;
    logic          hit, acc_up, acc_dn, det_clr, done;
    logic [1:0]    phase;
    logic [CW-1:0] ref_code;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    int exp_ph [NWIN];
    int exp_cd [NWIN];

    // {adc_code, hit, acc_up, acc_dn} with the window open at offset code 0
    localparam bit [6:0] VEC [0:5] = '{
        {4'd0,  1'b1, 1'b0, 1'b1},
        {4'd1,  1'b0, 1'b0, 1'b0},
        {4'd8,  1'b0, 1'b0, 1'b0},
        {4'd15, 1'b0, 1'b0, 1'b0},
        {4'd0,  1'b1, 1'b0, 1'b1},
        {4'd2,  1'b0, 1'b0, 1'b0}
    };

    always #4 clk = ~clk;

    hist_phase_seq #(.CODE_W(CW), .GAIN_LO(G_LO), .GAIN_HI(G_HI)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .win_end(win_end),
        .adc_code(adc_code), .hit(hit), .phase(phase), .ref_code(ref_code),
        .acc_up(acc_up), .acc_dn(acc_dn), .det_clr(det_clr), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one window; expects the given phase and code once it opens.
    task automatic run_window(input int ph, input int cd);
        bit dn_exp;
        @(negedge clk);
        start = 1'b1;
        #1;
        chk("R3 det_clr on start", det_clr, 1);
        @(negedge clk);
        start = 1'b0;
        chk("R4 phase", phase, ph);
        chk(ph == 1 ? "R5 gain code" : (ph == 0 ? "R4 offset code" : "R6 code"), ref_code, cd);
        adc_code = CW'(cd);
        #1;
        dn_exp = (ph == 0 && cd == 0);
        chk("R2 hit on match", hit, 1);
        chk("R7 acc_dn", acc_dn, dn_exp);
        chk("R7 acc_up", acc_up, !dn_exp);
        adc_code = CW'(cd) ^ CW'(1);
        #1;
        chk("R2 no hit on mismatch", hit, 0);
        @(negedge clk);
        win_end = 1'b1;
        @(negedge clk);
        win_end = 1'b0;
        adc_code = ref_code;
        #1;
        chk("R2 hit masked outside window", hit, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int k = 0;
        exp_ph[k] = 0; exp_cd[k] = 0;   k++;
        exp_ph[k] = 0; exp_cd[k] = TOP; k++;
        for (int c = G_LO; c <= G_HI; c++) begin exp_ph[k] = 1; exp_cd[k] = c; k++; end
        for (int c = 0; c <= TOP; c++) begin exp_ph[k] = 2; exp_cd[k] = c; k++; end
        for (int c = 0; c <= TOP; c++) begin exp_ph[k] = 3; exp_cd[k] = c; k++; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 phase", phase, 0);
        chk("R1 ref_code", ref_code, 0);
        chk("R1 hit", hit, 0);
        chk("R1 strobes", {acc_up, acc_dn}, 0);
        chk("R1 det_clr", det_clr, 0);
        chk("R1 done", done, 0);

        // R8: win_end while idle has no effect
        @(negedge clk);
        win_end = 1'b1;
        @(negedge clk);
        win_end = 1'b0;
        adc_code = '0;
        #1;
        chk("R8 idle win_end hit", hit, 0);
        chk("R8 idle win_end code", ref_code, 0);

        // Open the first window and walk the vector table (R2, R7)
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int v = 0; v < 6; v++) begin
            adc_code = VEC[v][6:3];
            #1;
            chk("R2 vector hit", hit, VEC[v][2]);
            chk("R7 vector acc_up", acc_up, VEC[v][1]);
            chk("R7 vector acc_dn", acc_dn, VEC[v][0]);
            @(negedge clk);
        end
        // R8: start inside window has no effect
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        adc_code = '0;
        #1;
        chk("R8 start in window keeps code", ref_code, 0);
        chk("R8 start in window keeps window", hit, 1);
        win_end = 1'b1;
        @(negedge clk);
        win_end = 1'b0;
        chk("R4 offset advances to top", ref_code, TOP);

        // Full sequence from a fresh reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int w = 0; w < NWIN; w++) begin
            run_window(exp_ph[w], exp_cd[w]);
            if (w == NWIN - 1) chk("R9 done after last window", done, 1);
            else               chk("R9 no early done", done, 0);
        end
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        adc_code = CW'(TOP);
        #1;
        chk("R9 idle after done", hit, 0);

        // R9: restart from offset
        run_window(0, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule